// File: doc/BRIEF.md
# SCSI Initiator Phase Checker with Interrupt Causes

This block sits between a host register port and the control lines of a SCSI bus on the initiator side. The host issues a sequence command whose low nibble names the information-transfer phase it expects, together with a beat count. While the command is active, the block looks at the phase lines {MSG, C/D, I/O} whenever the target raises REQ. A matching phase with ACK high counts one beat. The last beat completes the command. A differing phase aborts the command and records a phase-mismatch exception.

Other bus events come in as single-cycle pulses. These are selection, reselection, lost arbitration, selection timeout, unexpected disconnect and parity error. Each one sets a cause bit in one of two registers: an exception register and an error register. A three-bit interrupt summary holds command done together with the OR of each cause register. This summary is masked by a host-written mask and reduced to a single interrupt line. Cause bits and the command-done bit are cleared by writing ones to them.

Top module: `scsi_phase_chk`

## Requirements
- R1: After reset, the exception register, error register, interrupt summary and interrupt mask all read zero, and `busy`, `atn_out` and `irq` are low.
- R2: A sequence write (`wr_sel`=0) made while idle, with low nibble 3 (command), 4 (status), 5 (data-out), 6 (data-in), 7 (message-out) or 8 (message-in), starts a command from the next cycle on. The expected phase {MSG,C/D,I/O} is 010, 011, 000, 001, 110 or 111 respectively. While the command runs, `atn_out` follows bit 5 of the written byte.
- R3: While busy, each cycle with REQ and ACK high and the phase equal to the expected phase is one beat. The beat that brings the count to zero ends the command and sets command done (summary bit 0). A command started with count 0 sets command done at once, and `busy` stays low.
- R4: While busy with REQ high and a phase that differs from the expected phase, the block sets exception bit 1 (phase mismatch) and ends the command. Command done is not set.
- R5: A sequence write whose low nibble is outside 3..8, or any sequence write made while busy, sets error bit 4 (sequence error). It does not start a command and does not change the running command.
- R6: Event pulses set exception bits: 5 for selected with ATN, 4 for selected, 3 for reselected, 2 for arbitration lost and 0 for selection timeout. They set error bits 6 for unexpected disconnect and 0 for parity. Exception bits 7:6 and error bits 7 and 3:1 always read zero.
- R7: `bus_rst` high sets error bit 5 and ends any active command. In that cycle it also suppresses a phase mismatch, a beat and a command start.
- R8: A write with `wr_sel`=1 clears the exception bits where `wr_data` has ones. `wr_sel`=2 does the same for the error bits, and `wr_sel`=4 clears command done through bit 0. A cause bit that is set in the same cycle as its clear stays set.
- R9: The interrupt summary is {error register nonzero, exception register nonzero, command done}. `wr_sel`=3 loads the mask from `wr_data[2:0]`, and `irq` is high exactly when some summary bit and its mask bit are both set.
- R10: With REQ low, the phase lines and ACK have no effect on a running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Write target: 0 sequence, 1 exception clear, 2 error clear, 3 mask, 4 done clear |
| wr_data | input | 8 | Host write data |
| wr_count | input | CNT_W | Beat count loaded with a sequence write |
| bus_req | input | 1 | REQ line |
| bus_ack | input | 1 | ACK line |
| bus_msg | input | 1 | MSG line |
| bus_cd | input | 1 | C/D line |
| bus_io | input | 1 | I/O line |
| bus_rst | input | 1 | RST line |
| ev_sel_atn | input | 1 | Pulse: selected with ATN |
| ev_sel | input | 1 | Pulse: selected without ATN |
| ev_resel | input | 1 | Pulse: reselected |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_sel_tmo | input | 1 | Pulse: selection timeout |
| ev_disconnect | input | 1 | Pulse: unexpected disconnect |
| ev_parity | input | 1 | Pulse: parity error |
| busy | output | 1 | Command active |
| atn_out | output | 1 | ATN request from the active command |
| exc_q | output | 8 | Exception cause register |
| err_q | output | 8 | Error cause register |
| int_stat | output | 3 | Interrupt summary {error, exception, done} |
| int_mask_q | output | 3 | Interrupt mask |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check, on every cycle, the behaviour that follows a single event. A mismatch leaves the block idle with exception bit 1 set. A last beat raises command done. A bus reset sets its error bit and drops `busy`. An illegal or overlapping sequence write sets the sequence error. Reserved cause bits stay zero, and `irq` stays low when the mask is zero. Some behaviour appears only in the bench's scenarios: whole transfers of random length and phase, mismatches injected part way through, and idle REQ-low cycles that carry stray phase values. The same goes for the rule that a set outranks a clear in the same cycle, the precedence of bus reset over a same-cycle mismatch, and the progress of the mask through a sequence of host writes.

// File: rtl/scsi_phase_chk.sv
module scsi_phase_chk #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             bus_req,
  input  logic             bus_ack,
  input  logic             bus_msg,
  input  logic             bus_cd,
  input  logic             bus_io,
  input  logic             bus_rst,
  input  logic             ev_sel_atn,
  input  logic             ev_sel,
  input  logic             ev_resel,
  input  logic             ev_arb_lost,
  input  logic             ev_sel_tmo,
  input  logic             ev_disconnect,
  input  logic             ev_parity,
  output logic             busy,
  output logic             atn_out,
  output logic [7:0]       exc_q,
  output logic [7:0]       err_q,
  output logic [2:0]       int_stat,
  output logic [2:0]       int_mask_q,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [2:0]       exp_ph;
  logic [CNT_W-1:0] cnt;
  logic             atn_q;
  logic             done_q;

  function automatic logic [2:0] phase_of(input logic [3:0] code);
    case (code)
      4'd3:    phase_of = 3'b010;
      4'd4:    phase_of = 3'b011;
      4'd5:    phase_of = 3'b000;
      4'd6:    phase_of = 3'b001;
      4'd7:    phase_of = 3'b110;
      default: phase_of = 3'b111;
    endcase
  endfunction

  wire [2:0] bus_ph  = {bus_msg, bus_cd, bus_io};
  wire       seq_wr  = wr_en && (wr_sel == 3'd0);
  wire [3:0] code    = wr_data[3:0];
  wire       code_ok = (code >= 4'd3) && (code <= 4'd8);
  wire       start   = seq_wr && !busy && code_ok && !bus_rst;
  wire       mism    = busy && bus_req && (bus_ph != exp_ph) && !bus_rst;
  wire       beat    = busy && bus_req && bus_ack && (bus_ph == exp_ph) && !bus_rst;
  wire       last    = beat && (cnt == ONE);
  wire       done_set = last || (start && (wr_count == '0));

  wire [7:0] exc_set = {2'b00, ev_sel_atn, ev_sel, ev_resel, ev_arb_lost, mism, ev_sel_tmo};
  wire [7:0] err_set = {1'b0, ev_disconnect, bus_rst, seq_wr && (!code_ok || busy), 3'b000, ev_parity};
  wire [7:0] exc_clr = (wr_en && wr_sel == 3'd1) ? wr_data : 8'h00;
  wire [7:0] err_clr = (wr_en && wr_sel == 3'd2) ? wr_data : 8'h00;
  wire       done_clr = wr_en && (wr_sel == 3'd4) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      exp_ph     <= 3'b000;
      cnt        <= '0;
      atn_q      <= 1'b0;
      done_q     <= 1'b0;
      exc_q      <= 8'h00;
      err_q      <= 8'h00;
      int_mask_q <= 3'b000;
    end else begin
      if (bus_rst) begin
        busy <= 1'b0;
      end else if (start) begin
        busy   <= (wr_count != '0);
        exp_ph <= phase_of(code);
        cnt    <= wr_count;
        atn_q  <= wr_data[5];
      end else if (mism || last) begin
        busy <= 1'b0;
      end
      if (beat) cnt <= cnt - ONE;
      done_q <= (done_q && !done_clr) || done_set;
      exc_q  <= (exc_q & ~exc_clr) | exc_set;
      err_q  <= (err_q & ~err_clr) | err_set;
      if (wr_en && wr_sel == 3'd3) int_mask_q <= wr_data[2:0];
    end
  end

  assign atn_out  = busy && atn_q;
  assign int_stat = {|err_q, |exc_q, done_q};
  assign irq      = |(int_stat & int_mask_q);

  a_r4_mismatch_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_req && bus_ph != exp_ph && !bus_rst) |=> (exc_q[1] && !busy));

  a_r3_last_beat_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_req && bus_ack && bus_ph == exp_ph && cnt == ONE && !bus_rst) |=> (int_stat[0] && !busy));

  a_r7_reset_line: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (err_q[5] && !busy));

  a_r5_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && !(wr_data[3:0] >= 4'd3 && wr_data[3:0] <= 4'd8)) |=> (err_q[4] && !$rose(busy)));

  a_r5_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && busy && !bus_rst && !bus_req) |=> (err_q[4] && busy && $stable(exp_ph)));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q[7:6] == 2'b00) && (err_q[7] == 1'b0) && (err_q[3:1] == 3'b000));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask_q == 3'b000) |-> !irq);

  a_r10_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_req && !bus_rst) |=> busy);

endmodule

// File: tb/scsi_phase_chk_tb.sv
module scsi_phase_chk_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [CNT_W-1:0] wr_count = '0;
  logic bus_req = 1'b0, bus_ack = 1'b0, bus_msg = 1'b0, bus_cd = 1'b0, bus_io = 1'b0, bus_rst = 1'b0;
  logic ev_sel_atn = 1'b0, ev_sel = 1'b0, ev_resel = 1'b0, ev_arb_lost = 1'b0;
  logic ev_sel_tmo = 1'b0, ev_disconnect = 1'b0, ev_parity = 1'b0;
  logic busy, atn_out, irq;
  logic [7:0] exc_q, err_q;
  logic [2:0] int_stat, int_mask_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scsi_phase_chk #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_count(wr_count),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io),
    .bus_rst(bus_rst), .ev_sel_atn(ev_sel_atn), .ev_sel(ev_sel), .ev_resel(ev_resel),
    .ev_arb_lost(ev_arb_lost), .ev_sel_tmo(ev_sel_tmo), .ev_disconnect(ev_disconnect),
    .ev_parity(ev_parity), .busy(busy), .atn_out(atn_out), .exc_q(exc_q), .err_q(err_q),
    .int_stat(int_stat), .int_mask_q(int_mask_q), .irq(irq)
  );

  function automatic logic [2:0] want_phase(input logic [3:0] c);
    case (c)
      4'd3: return 3'b010;
      4'd4: return 3'b011;
      4'd5: return 3'b000;
      4'd6: return 3'b001;
      4'd7: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; bus_req = 0; bus_ack = 0; bus_rst = 0;
    ev_sel_atn = 0; ev_sel = 0; ev_resel = 0; ev_arb_lost = 0;
    ev_sel_tmo = 0; ev_disconnect = 0; ev_parity = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  task automatic hwr(input logic [2:0] s, input logic [7:0] d, input logic [CNT_W-1:0] n);
    wr_en = 1; wr_sel = s; wr_data = d; wr_count = n;
    tick();
  endtask

  task automatic bus(input logic r, input logic a, input logic [2:0] ph);
    bus_req = r; bus_ack = a; {bus_msg, bus_cd, bus_io} = ph;
    tick();
  endtask

  task automatic clear_all();
    hwr(3'd1, 8'hff, '0);
    hwr(3'd2, 8'hff, '0);
    hwr(3'd4, 8'h01, '0);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5c51));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 exc", exc_q, 0); chk("R1 err", err_q, 0); chk("R1 int", int_stat, 0);
    chk("R1 mask", int_mask_q, 0); chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
    chk("R1 atn", atn_out, 0);

    hwr(3'd3, 8'h07, '0);
    chk("R9 mask load", int_mask_q, 3'b111);

    hwr(3'd0, 8'h23, 16'd2);
    chk("R2 busy", busy, 1); chk("R2 atn", atn_out, 1);
    bus(1, 1, 3'b010);
    chk("R3 mid", busy, 1);
    bus(1, 1, 3'b010);
    chk("R3 end", busy, 0); chk("R3 done", int_stat, 3'b001); chk("R9 irq", irq, 1);
    chk("R2 atn off", atn_out, 0);
    hwr(3'd4, 8'h01, '0);
    chk("R8 done clr", int_stat, 0);

    hwr(3'd0, 8'h06, '0);
    chk("R3 zero busy", busy, 0); chk("R3 zero done", int_stat[0], 1);
    hwr(3'd4, 8'h01, '0);

    hwr(3'd0, 8'h05, 16'd3);
    chk("R2 no atn", atn_out, 0);
    bus(0, 1, 3'b111);
    chk("R10 ignored", busy, 1); chk("R10 exc", exc_q, 0);
    bus(1, 0, 3'b000);
    chk("R10 req no ack", busy, 1);
    bus(1, 1, 3'b011);
    chk("R4 exc", exc_q, 8'h02); chk("R4 busy", busy, 0); chk("R4 int", int_stat, 3'b010);
    hwr(3'd1, 8'h02, '0);
    chk("R8 exc clr", exc_q, 0);

    hwr(3'd0, 8'h0b, 16'd1);
    chk("R5 bad err", err_q, 8'h10); chk("R5 bad idle", busy, 0);
    hwr(3'd2, 8'h10, '0);
    hwr(3'd0, 8'h00, 16'd1);
    chk("R5 code0", err_q, 8'h10);
    hwr(3'd2, 8'h10, '0);
    hwr(3'd0, 8'h04, 16'd2);
    hwr(3'd0, 8'h08, 16'd1);
    chk("R5 busy err", err_q, 8'h10); chk("R5 busy kept", busy, 1);
    bus(1, 1, 3'b011);
    chk("R5 phase kept", {exc_q[1], busy}, 2'b01);
    bus_rst = 1; bus(1, 1, 3'b000);
    chk("R7 err", err_q, 8'h30); chk("R7 busy", busy, 0); chk("R7 no mism", exc_q, 0);
    clear_all();

    ev_sel_atn = 1; ev_sel = 1; ev_resel = 1; ev_arb_lost = 1; ev_sel_tmo = 1; tick();
    chk("R6 exc", exc_q, 8'h3d);
    ev_disconnect = 1; ev_parity = 1; tick();
    chk("R6 err", err_q, 8'h41);
    clear_all();
    chk("R8 all clear", {exc_q, err_q}, 16'h0);

    ev_arb_lost = 1; hwr(3'd1, 8'h04, '0);
    chk("R8 set wins", exc_q, 8'h04);
    hwr(3'd3, 8'h00, '0);
    chk("R9 masked", irq, 0);
    hwr(3'd3, 8'h04, '0);
    chk("R9 other bit", irq, 0);
    hwr(3'd3, 8'h02, '0);
    chk("R9 exc irq", irq, 1);
    clear_all();
    hwr(3'd3, 8'h07, '0);

    for (int it = 0; it < 60; it++) begin
      logic [3:0] c;
      logic [2:0] ph, bad;
      int n, k;
      c = 4'(3 + $urandom_range(0, 5));
      ph = want_phase(c);
      n = $urandom_range(1, 5);
      k = $urandom_range(0, 7);
      hwr(3'd0, {2'b00, 1'($urandom_range(0, 1)), 1'b0, c}, CNT_W'(n));
      chk("R2 rand start", busy, 1);
      for (int b = 0; b < n; b++) begin
        if ($urandom_range(0, 2) == 0) bus(0, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
        if (b == k) begin
          bad = 3'($urandom_range(0, 7));
          if (bad == ph) bad = ph ^ 3'b100;
          bus(1, 1'($urandom_range(0, 1)), bad);
          break;
        end
        bus(1, 1, ph);
      end
      if (k < n) begin
        chk("R4 rand", {busy, exc_q, int_stat}, {1'b0, 8'h02, 3'b010});
      end else begin
        chk("R3 rand", {busy, exc_q, int_stat}, {1'b0, 8'h00, 3'b001});
      end
      clear_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule